// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Overflow

This block clamps a 64-bit two's-complement value to a narrower range of 8, 16 or 32 bits, in signed or unsigned mode. It also adds two 64-bit signed operands and limits the sum to the 64-bit range. Results are combinational and leave on a result stream that mirrors the operand stream. A status bit records overflow and stays set until it is cleared. The bit is set when a scalar operation had to change its value to fit. Operations issued in vector mode give exactly the same results but never set the bit.

Out-of-range detection compares the operand with its own sign extension (signed mode) or zero extension (unsigned mode) taken from bit N-1. If the two are equal, the operand already fits and passes through unchanged. If not, the operand's sign picks the bound it is clamped to.

The operand and result interfaces form one valid/ready stream with no storage. `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`. An operation is accepted on a clock edge where both `in_valid` and `out_ready` are high. When the consumer holds `out_ready` low, the operand must be held by the producer. Only an accepted operation may change the overflow bit.

Top module: `sat_arith_unit`

## Requirements
- R1: In signed mode (`op_sel`=0) an operand equal to the sign extension of its low N bits is returned unchanged, where N is 8, 16 or 32 for `width_sel` 1, 2 or 3.
- R2: In signed mode an operand that does not fit returns -(2^(N-1)) if bit 63 is set, and 2^(N-1)-1 otherwise, sign-extended to 64 bits.
- R3: In unsigned mode (`op_sel`=1) an operand equal to the zero extension of its low N bits is returned unchanged. Otherwise the result is 0 if bit 63 is set, and 2^N-1 if it is clear.
- R4: With `width_sel`=0 both narrowing modes return zero and report no clamp.
- R5: In add mode (`op_sel`=2 or 3, `width_sel` ignored), the plain 64-bit sum is returned when the operand sign bits differ. It is also returned when the signs match and the sum keeps that sign.
- R6: In add mode, when the operand signs match and the sum's sign differs from them, the result is 0x7FFF_FFFF_FFFF_FFFF if the sum's bit 63 is set. It is 0x8000_0000_0000_0000 if that bit is clear.
- R7: An accepted scalar operation (`vec_mode`=0) that clamps sets `ovf_flag` at that clock edge. The flag then stays set through any later operation that does not clamp.
- R8: With `vec_mode`=1 the result equals the scalar result, and `ovf_flag` is left unchanged.
- R9: `flag_clr` clears `ovf_flag` at the next edge. If an accepted scalar clamp happens on the same edge, the flag ends up set.
- R10: `out_valid` equals `in_valid`, and `in_ready` equals `out_ready`. The flag changes only on an edge where both `in_valid` and `out_ready` are high.
- R11: An active-low `rst_n` clears `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand stream valid |
| in_ready | output | 1 | Operand stream ready (follows out_ready) |
| op_sel | input | 2 | 0 signed narrow, 1 unsigned narrow, 2/3 saturating add |
| width_sel | input | 2 | 0 zero width, 1 = 8, 2 = 16, 3 = 32 bits |
| vec_mode | input | 1 | Vector form: same result, flag untouched |
| op_a | input | 64 | Operand to narrow, or first addend |
| op_b | input | 64 | Second addend |
| flag_clr | input | 1 | Clear the overflow flag |
| out_valid | output | 1 | Result stream valid (follows in_valid) |
| out_ready | input | 1 | Result stream ready |
| result | output | 64 | Saturated result |
| ovf_flag | output | 1 | Sticky overflow status |

## Verification
The narrowing paths are tried with values just inside and just outside each width's range on both signs. This tells a correct extension compare apart from an off-by-one bound or a sign test on the wrong bit. The add is exercised with mixed-sign operands near the extremes, same-sign operands that stay in range, and positive and negative overflow. These cases separate the three branches of the add. Each table vector is repeated in vector mode and under a stalled or idle handshake, which shows whether a clamp is being gated correctly from the flag.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef enum logic [1:0] {
    OP_SSAT    = 2'd0,
    OP_USAT    = 2'd1,
    OP_ADD     = 2'd2,
    OP_ADD_ALT = 2'd3
  } sat_op_e;

  localparam int unsigned NUM_WIDTHS = 3;

  function automatic logic is_add(sat_op_e op);
    return op[1];
  endfunction

endpackage

// File: rtl/sat_narrow.sv
module sat_narrow #(
  parameter int unsigned DW = 64,
  parameter int unsigned W0 = 8,
  parameter int unsigned W1 = 16,
  parameter int unsigned W2 = 32
) (
  input  logic [DW-1:0] val_i,
  input  logic [1:0]    wcode_i,
  input  logic          unsigned_i,
  output logic [DW-1:0] res_o,
  output logic          clamp_o
);
  import sat_pkg::*;

  logic [DW-1:0] cand_res   [NUM_WIDTHS];
  logic          cand_clamp [NUM_WIDTHS];

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    localparam int unsigned N = (g == 0) ? W0 : ((g == 1) ? W1 : W2);
    logic [DW-1:0] sx, zx, smax, smin, umax;
    logic          s_fit, u_fit, neg;

    assign sx   = {{(DW-N){val_i[N-1]}}, val_i[N-1:0]};
    assign zx   = {{(DW-N){1'b0}}, val_i[N-1:0]};
    assign smax = {{(DW-N+1){1'b0}}, {(N-1){1'b1}}};
    assign smin = {{(DW-N+1){1'b1}}, {(N-1){1'b0}}};
    assign umax = {{(DW-N){1'b0}}, {N{1'b1}}};
    assign neg  = val_i[DW-1];
    assign s_fit = (sx == val_i);
    assign u_fit = (zx == val_i);

    assign cand_res[g] = unsigned_i
                         ? (u_fit ? val_i : (neg ? '0 : umax))
                         : (s_fit ? val_i : (neg ? smin : smax));
    assign cand_clamp[g] = unsigned_i ? !u_fit : !s_fit;
  end

  always_comb begin
    res_o   = '0;
    clamp_o = 1'b0;
    case (wcode_i)
      2'd1: begin res_o = cand_res[0]; clamp_o = cand_clamp[0]; end
      2'd2: begin res_o = cand_res[1]; clamp_o = cand_clamp[1]; end
      2'd3: begin res_o = cand_res[2]; clamp_o = cand_clamp[2]; end
      default: begin res_o = '0; clamp_o = 1'b0; end
    endcase
  end

endmodule

// File: rtl/sat_add.sv
module sat_add #(
  parameter int unsigned DW = 64
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o,
  output logic          clamp_o
);
  logic [DW-1:0] sum;
  logic          same_sign;

  assign sum       = a_i + b_i;
  assign same_sign = (a_i[DW-1] == b_i[DW-1]);
  assign clamp_o   = same_sign && (sum[DW-1] != a_i[DW-1]);
  assign res_o     = !clamp_o ? sum
                   : (sum[DW-1] ? {1'b0, {(DW-1){1'b1}}}
                                : {1'b1, {(DW-1){1'b0}}});

endmodule

// File: rtl/sat_sticky_flag.sv
module sat_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit #(
  parameter int unsigned DW = 64,
  parameter int unsigned W0 = 8,
  parameter int unsigned W1 = 16,
  parameter int unsigned W2 = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    op_sel,
  input  logic [1:0]    width_sel,
  input  logic          vec_mode,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          flag_clr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] result,
  output logic          ovf_flag
);
  import sat_pkg::*;

  sat_op_e       op;
  logic [DW-1:0] nar_res, add_res;
  logic          nar_clamp, add_clamp, clamp, fire, flag_set;

  assign op = sat_op_e'(op_sel);

  sat_narrow #(.DW(DW), .W0(W0), .W1(W1), .W2(W2)) u_narrow (
    .val_i      (op_a),
    .wcode_i    (width_sel),
    .unsigned_i (op == OP_USAT),
    .res_o      (nar_res),
    .clamp_o    (nar_clamp)
  );

  sat_add #(.DW(DW)) u_add (
    .a_i     (op_a),
    .b_i     (op_b),
    .res_o   (add_res),
    .clamp_o (add_clamp)
  );

  assign result    = is_add(op) ? add_res : nar_res;
  assign clamp     = is_add(op) ? add_clamp : nar_clamp;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign fire      = in_valid && out_ready;
  assign flag_set  = fire && clamp && !vec_mode;

  sat_sticky_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_o (ovf_flag)
  );

  // R2
  ssat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_SSAT && width_sel == 2'd1)
      |-> (result[DW-1:W0-1] == {(DW-W0+1){result[W0-1]}}));

  // R3
  usat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_USAT && width_sel == 2'd1)
      |-> (result[DW-1:W0] == '0));

  // R4
  zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_add(op) && width_sel == 2'd0) |-> (result == '0));

  // R6
  add_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_add(op) && op_a[DW-1] == op_b[DW-1])
      |-> (result[DW-1] == op_a[DW-1]));

  // R8
  vec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_mode && !ovf_flag) |=> !ovf_flag);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && out_ready) && !ovf_flag) |=> !ovf_flag);

endmodule

// File: tb/tb_sat_arith_unit.sv
module tb_sat_arith_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  op_sel = 2'd0;
  logic [1:0]  width_sel = 2'd0;
  logic        vec_mode = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        flag_clr = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] result;
  logic        ovf_flag;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sat_arith_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_sel(op_sel), .width_sel(width_sel), .vec_mode(vec_mode),
    .op_a(op_a), .op_b(op_b), .flag_clr(flag_clr), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .ovf_flag(ovf_flag)
  );

  // {op, width, vec, a, b, expected result, expected clamp}
  localparam int NV = 20;
  localparam logic [197:0] VECS [NV] = '{
    {2'd0, 2'd1, 1'b0, 64'h0000_0000_0000_007F, 64'h0, 64'h0000_0000_0000_007F, 1'b0}, // R1
    {2'd0, 2'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FF80, 64'h0, 64'hFFFF_FFFF_FFFF_FF80, 1'b0}, // R1
    {2'd0, 2'd1, 1'b0, 64'h0000_0000_0000_0080, 64'h0, 64'h0000_0000_0000_007F, 1'b1}, // R2
    {2'd0, 2'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FF7F, 64'h0, 64'hFFFF_FFFF_FFFF_FF80, 1'b1}, // R2
    {2'd0, 2'd2, 1'b0, 64'h0000_0001_0000_0000, 64'h0, 64'h0000_0000_0000_7FFF, 1'b1}, // R2
    {2'd0, 2'd3, 1'b0, 64'h8000_0000_0000_0000, 64'h0, 64'hFFFF_FFFF_8000_0000, 1'b1}, // R2
    {2'd0, 2'd3, 1'b0, 64'hFFFF_FFFF_8000_0000, 64'h0, 64'hFFFF_FFFF_8000_0000, 1'b0}, // R1
    {2'd1, 2'd1, 1'b0, 64'h0000_0000_0000_00FF, 64'h0, 64'h0000_0000_0000_00FF, 1'b0}, // R3
    {2'd1, 2'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0000_0000_0000_0000, 1'b1}, // R3
    {2'd1, 2'd2, 1'b0, 64'h0000_0000_0001_0000, 64'h0, 64'h0000_0000_0000_FFFF, 1'b1}, // R3
    {2'd1, 2'd3, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'h0, 64'h0000_0000_FFFF_FFFF, 1'b0}, // R3
    {2'd0, 2'd0, 1'b0, 64'h0000_0000_0000_1234, 64'h0, 64'h0000_0000_0000_0000, 1'b0}, // R4
    {2'd1, 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0000_0000_0000_0000, 1'b0}, // R4
    {2'd2, 2'd1, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFE, 1'b0}, // R5
    {2'd2, 2'd0, 1'b0, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0007, 64'h0000_0000_0000_000C, 1'b0}, // R5
    {2'd2, 2'd2, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1}, // R6
    {2'd2, 2'd3, 1'b0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b1}, // R6
    {2'd3, 2'd0, 1'b0, 64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1}, // R6
    {2'd0, 2'd1, 1'b1, 64'h0000_0000_0000_0080, 64'h0, 64'h0000_0000_0000_007F, 1'b1}, // R8
    {2'd2, 2'd0, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1}  // R8
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [1:0] w, input logic v,
                       input logic [63:0] a, input logic [63:0] b);
    op_sel = op; width_sel = w; vec_mode = v; op_a = a; op_b = b;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    in_valid = 1'b0; flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #12;
    // R11 reset state
    chk("R11 reset flag", {63'd0, ovf_flag}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [197:0] e;
      e = VECS[i];
      clear_flag();
      drive(e[197:196], e[195:194], e[193], e[192:129], e[128:65]);
      in_valid = 1'b1;
      #1;
      chk($sformatf("R1-6 vector %0d result", i), result, e[64:1]);
      @(negedge clk);
      in_valid = 1'b0;
      chk($sformatf("R7/R8 vector %0d flag", i), {63'd0, ovf_flag},
          {63'd0, e[0] && !e[193]});
    end

    // R7 sticky through a non-clamping op
    clear_flag();
    drive(2'd0, 2'd1, 1'b0, 64'h80, 64'h0); in_valid = 1'b1;
    @(negedge clk);
    drive(2'd0, 2'd1, 1'b0, 64'h10, 64'h0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 flag sticky", {63'd0, ovf_flag}, 64'd1);

    // R8 vector clamp with flag already set leaves it set
    drive(2'd1, 2'd1, 1'b1, 64'h100, 64'h0); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 vector keeps flag", {63'd0, ovf_flag}, 64'd1);

    // R9 clear
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R9 clear", {63'd0, ovf_flag}, 64'd0);

    // R9 clear and clamp on same edge
    drive(2'd0, 2'd2, 1'b0, 64'h8000, 64'h0); in_valid = 1'b1; flag_clr = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; flag_clr = 1'b0;
    chk("R9 set wins", {63'd0, ovf_flag}, 64'd1);

    // R10 stalled: no acceptance, no flag
    clear_flag();
    out_ready = 1'b0;
    drive(2'd0, 2'd1, 1'b0, 64'h80, 64'h0); in_valid = 1'b1;
    #1;
    chk("R10 in_ready follows out_ready", {63'd0, in_ready}, 64'd0);
    chk("R10 out_valid follows in_valid", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    chk("R10 stalled no flag", {63'd0, ovf_flag}, 64'd0);

    // R10 idle: ready but no valid
    out_ready = 1'b1; in_valid = 1'b0;
    #1;
    chk("R10 idle out_valid", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    chk("R10 idle no flag", {63'd0, ovf_flag}, 64'd0);

    // R11 reset clears a set flag
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 flag set before reset", {63'd0, ovf_flag}, 64'd1);
    rst_n = 1'b0;
    #1;
    chk("R11 reset clears", {63'd0, ovf_flag}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule